// File: doc/BRIEF.md
# Consumer-Infrared Receive Sampler

This block takes a demodulated consumer-infrared line and turns it into a stream of bytes for a receive queue. It stays inactive until modulated energy appears whose carrier the upstream detector has judged to lie inside the programmed band. That judgement arrives on `freq_ok`. Once armed, the block samples the line at a fixed rate set by a 16-bit divisor. It packs each sample, least significant bit first, into bytes and hands every completed byte out with a one-cycle valid flag.

Two sampling modes exist. In oversampled mode the sample timer free-runs, and the byte stream is a raw snapshot of the line. In T-period mode every new energy pulse restarts the sample timer, so that the sample phase follows the incoming edges. The host sees two status bits. The first is an active flag, which it can clear by writing 1. The second is a pulse watchdog, which is set by each pulse and cleared by a status read. Software uses the watchdog to tell when the link has gone quiet.

Top module: `cir_rx_sampler`

## Requirements
- R1: While inactive, the receiver arms only on a cycle where `ir_in` is 0 and `freq_ok` is 1. Energy with `freq_ok` at 0 changes no output.
- R2: `st_active` goes to 1 on the clock edge that samples the arming condition.
- R3: A sample is 1 when `ir_in` is 1 (idle) and 0 when `ir_in` is 0 (energy). A byte of constant idle reads 0xFF, and a byte of constant energy reads 0x00.
- R4: While active, a sample is taken every D clock cycles, whether or not pulses occur, where D is `divisor` and a divisor of 0 acts as 1. After arming, the first sample falls D cycles later.
- R5: Samples fill bytes LSB first: the first sample of a byte lands in bit 0. Each completed byte appears on `rx_byte`, with `rx_valid` high for exactly one cycle, on the edge after its eighth sample.
- R6: `st_wdog` is set on every 1-to-0 transition of `ir_in` seen while active or while arming. A `reg_rd` strobe clears it. If a set and a read fall in the same cycle, the set wins.
- R7: A `reg_wr` with `reg_wdata[0]` at 1 while active clears `st_active` on that edge. Any partly filled byte is discarded, and no byte is output while inactive.
- R8: With `tmode` at 1, a 1-to-0 transition of `ir_in` while active restarts the sample timer: no sample is taken in that cycle, and the next sample falls D cycles later.
- R9: After reset the block is inactive, the watchdog is clear and `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated line, 1 = idle, 0 = energy |
| freq_ok | input | 1 | Carrier lies inside the programmed band |
| tmode | input | 1 | 0 = oversampled, 1 = T-period resync |
| divisor | input | 16 | Sample period in clocks (0 acts as 1) |
| reg_rd | input | 1 | Status read strobe (clears watchdog) |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 8 | Write data, bit 0 = 1 deactivates |
| st_active | output | 1 | Receiver active flag |
| st_wdog | output | 1 | Pulse watchdog flag |
| rx_byte | output | 8 | Assembled byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |

## Verification
The bench targets the following corner cases.

- **Out-of-band bursts.** A design that arms on energy alone would wrongly report active.
- **Divisor of zero.** Such a design would either stall or sample at a period of 65536.
- **Restarting after a clear with a partial byte pending.** Leftover samples would corrupt the next byte.
- **Watchdog read against pulse timing.** A read that took priority over a set would lose a pulse.
- **T-period pulses arriving faster than the divisor.** A timer that failed to restart would emit bytes where none may appear. The same pattern in oversampled mode must still produce bytes.

A known asymmetric byte, 0xA5, exposes bit-order reversal.

// File: rtl/cir_pkg.sv
package cir_pkg;
    typedef struct packed {
        logic active;
        logic wdog;
        logic ir_prev;
    } cir_ctrl_t;
endpackage

// File: rtl/cir_ctrl.sv
module cir_ctrl
    import cir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ir_in,
    input  logic freq_ok,
    input  logic clr_req,
    input  logic rd_stb,
    output logic active,
    output logic wdog,
    output logic arm,
    output logic pulse
);
    cir_ctrl_t r_q, r_d;

    always_comb begin
        r_d   = r_q;
        pulse = r_q.ir_prev & ~ir_in;
        arm   = ~r_q.active & ~ir_in & freq_ok;
        r_d.ir_prev = ir_in;
        if (r_q.active && clr_req) begin
            r_d.active = 1'b0;
        end else if (arm) begin
            r_d.active = 1'b1;
        end
        if (pulse && (r_q.active || arm)) begin
            r_d.wdog = 1'b1;
        end else if (rd_stb) begin
            r_d.wdog = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{active: 1'b0, wdog: 1'b0, ir_prev: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign active = r_q.active;
    assign wdog   = r_q.wdog;
endmodule

// File: rtl/cir_prescaler.sv
module cir_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic             resync,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_t;

    pre_t r_q, r_d;
    logic [DIV_W-1:0] reload;

    always_comb begin
        reload = (divisor == '0) ? '0 : divisor - 1'b1;
        r_d    = r_q;
        tick   = 1'b0;
        if (load) begin
            r_d.cnt = reload;
        end else if (!run) begin
            r_d.cnt = '0;
        end else if (resync) begin
            r_d.cnt = reload;
        end else if (r_q.cnt == '0) begin
            tick    = 1'b1;
            r_d.cnt = reload;
        end else begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/cir_deser.sv
module cir_deser #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              tick,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  bits;
        logic [BYTE_W-1:0] data;
        logic              vld;
    } des_t;

    des_t r_q, r_d;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        shifted = {bit_in, r_q.sh[BYTE_W-1:1]};
        if (flush) begin
            r_d.bits = '0;
        end else if (tick) begin
            r_d.sh = shifted;
            if (r_q.bits == LAST) begin
                r_d.bits = '0;
                r_d.data = shifted;
                r_d.vld  = 1'b1;
            end else begin
                r_d.bits = r_q.bits + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign byte_o  = r_q.data;
    assign valid_o = r_q.vld;
endmodule

// File: rtl/cir_rx_sampler.sv
module cir_rx_sampler #(
    parameter int DIV_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_in,
    input  logic              freq_ok,
    input  logic              tmode,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic              st_active,
    output logic              st_wdog,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);
    logic clr_req, arm_w, pulse_w, tick_w, resync_w;

    assign clr_req  = reg_wr & reg_wdata[0];
    assign resync_w = tmode & pulse_w;

    cir_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .freq_ok(freq_ok),
        .clr_req(clr_req), .rd_stb(reg_rd),
        .active(st_active), .wdog(st_wdog), .arm(arm_w), .pulse(pulse_w)
    );

    cir_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(st_active), .load(arm_w),
        .resync(resync_w), .divisor(divisor), .tick(tick_w)
    );

    cir_deser #(.BYTE_W(BYTE_W)) u_des (
        .clk(clk), .rst_n(rst_n), .flush(clr_req | ~st_active),
        .tick(tick_w), .bit_in(ir_in), .byte_o(rx_byte), .valid_o(rx_valid)
    );
endmodule

// File: rtl/cir_rx_sampler_chk.sv
module cir_rx_sampler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ir_in,
    input logic       freq_ok,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic       st_active,
    input logic       st_wdog,
    input logic       rx_valid,
    input logic       pulse
);
    AST_ARM_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_active) |-> ($past(freq_ok) && !$past(ir_in))); // R1
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_active && reg_wr && reg_wdata[0]) |=> !st_active); // R7
    AST_QUIET_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_active |-> !rx_valid); // R7
    AST_WDOG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !pulse) |=> !st_wdog); // R6
    AST_WDOG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && st_active) |=> st_wdog); // R6
    AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R5
endmodule

bind cir_rx_sampler cir_rx_sampler_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .freq_ok(freq_ok),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .st_active(st_active), .st_wdog(st_wdog), .rx_valid(rx_valid),
    .pulse(pulse_w)
);

// File: tb/cir_rx_sampler_tb.sv
module cir_rx_sampler_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ir_in = 1'b1, freq_ok = 1'b0, tmode = 1'b0;
    logic [15:0] divisor = 16'd1;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic st_active, st_wdog, rx_valid;
    logic [7:0] rx_byte;

    int n_chk = 0, n_fail = 0, cyc = 0, vcount = 0;
    logic [7:0] last_byte = 8'h00;

    // reference model state
    int m_act = 0, m_wdg = 0, m_prev = 1, m_cnt = 0, m_bits = 0, m_vld = 0;
    int m_sh = 0, m_byte = 0;

    always #5 clk = ~clk;

    cir_rx_sampler u_dut (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .freq_ok(freq_ok),
        .tmode(tmode), .divisor(divisor), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .st_active(st_active), .st_wdog(st_wdog),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (rst_n) begin
            int per, iv, edge_seen, armed, cleared, smp;
            per = (divisor == 0) ? 1 : int'(divisor);
            iv = int'(ir_in);
            edge_seen = (m_prev == 1 && iv == 0) ? 1 : 0;
            armed = (m_act == 0 && iv == 0 && freq_ok) ? 1 : 0;
            cleared = (reg_wr && reg_wdata[0]) ? 1 : 0;
            smp = (m_act == 1 && !(tmode && edge_seen) && m_cnt == 0) ? 1 : 0;
            m_vld = 0;
            if (cleared || m_act == 0) m_bits = 0;
            else if (smp) begin
                m_sh = (m_sh >> 1) | (iv << 7);
                m_bits++;
                if (m_bits == 8) begin
                    m_byte = m_sh; m_vld = 1; m_bits = 0;
                end
            end
            if (armed) m_cnt = per - 1;
            else if (m_act == 0) m_cnt = 0;
            else if ((tmode && edge_seen) || m_cnt == 0) m_cnt = per - 1;
            else m_cnt--;
            if (edge_seen && (m_act == 1 || armed)) m_wdg = 1;
            else if (reg_rd) m_wdg = 0;
            if (m_act == 1 && cleared) m_act = 0;
            else if (armed) m_act = 1;
            m_prev = iv;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(st_active == m_act[0], "R2 active", st_active, m_act);
            chk(st_wdog == m_wdg[0], "R6 wdog", st_wdog, m_wdg);
            chk(rx_valid == m_vld[0], "R5 valid", rx_valid, m_vld);
            if (rx_valid) begin
                chk(rx_byte == m_byte[7:0], "R5 byte", rx_byte, m_byte);
                vcount++;
                last_byte = rx_byte;
            end
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_arm();
        ir_in = 1'b0; freq_ok = 1'b1; step(1);
        freq_ok = 1'b0;
    endtask

    task automatic do_clear();
        reg_wr = 1'b1; reg_wdata = 8'h01; step(1);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    initial begin
        int v0;
        step(2);
        rst_n = 1'b1;
        // R9 reset state
        chk(st_active == 1'b0, "R9 active", st_active, 0);
        chk(st_wdog == 1'b0, "R9 wdog", st_wdog, 0);
        chk(rx_valid == 1'b0, "R9 valid", rx_valid, 0);

        // R1 out-of-band energy ignored
        ir_in = 1'b0; freq_ok = 1'b0; step(20);
        chk(st_active == 1'b0, "R1 out-of-band", st_active, 0);
        chk(st_wdog == 1'b0, "R1 wdog untouched", st_wdog, 0);
        ir_in = 1'b1; step(2);

        // R5 bit order with 0xA5, divisor 1
        divisor = 16'd1;
        do_arm();
        chk(st_active == 1'b1, "R2 armed", st_active, 1);
        for (int i = 0; i < 8; i++) begin
            ir_in = ((8'hA5 >> i) & 8'h01) != 0; step(1);
        end
        ir_in = 1'b1; step(1);
        chk(last_byte == 8'hA5, "R5 lsb-first", last_byte, 8'hA5);
        do_clear();
        chk(st_active == 1'b0, "R7 cleared", st_active, 0);

        // R3 constant energy gives 0x00
        do_arm();
        step(9);
        chk(last_byte == 8'h00, "R3 energy byte", last_byte, 0);
        ir_in = 1'b1;
        do_clear();

        // R4 divisor 0 acts as 1: 80 samples -> 10 bytes of 0xFF
        divisor = 16'd0;
        do_arm();
        ir_in = 1'b1; v0 = vcount;
        step(81);
        do_clear();
        chk(vcount - v0 == 10, "R4 div0 count", vcount - v0, 10);
        chk(last_byte == 8'hFF, "R3 idle byte", last_byte, 8'hFF);

        // R4 divisor 4: 20 samples -> 2 bytes
        divisor = 16'd4;
        do_arm();
        ir_in = 1'b1; v0 = vcount;
        step(81);
        do_clear();
        chk(vcount - v0 == 2, "R4 div4 count", vcount - v0, 2);

        // R7 partial byte discarded
        divisor = 16'd1;
        do_arm();
        ir_in = 1'b1; step(4);
        do_clear();
        step(2);
        do_arm();
        step(9);
        chk(last_byte == 8'h00, "R7 partial discarded", last_byte, 0);

        // R6 watchdog read then new pulse
        ir_in = 1'b1;
        reg_rd = 1'b1; step(1); reg_rd = 1'b0;
        chk(st_wdog == 1'b0, "R6 read clears", st_wdog, 0);
        ir_in = 1'b0; step(1);
        chk(st_wdog == 1'b1, "R6 pulse sets", st_wdog, 1);
        ir_in = 1'b1; step(1);
        ir_in = 1'b0; reg_rd = 1'b1; step(1); reg_rd = 1'b0;
        chk(st_wdog == 1'b1, "R6 set beats read", st_wdog, 1);
        ir_in = 1'b1;
        do_clear();

        // R8 T-period: pulses every 3 cycles, divisor 4 -> no sample ever
        tmode = 1'b1; divisor = 16'd4;
        do_arm();
        v0 = vcount;
        for (int k = 0; k < 30; k++) begin
            ir_in = 1'b1; step(2); ir_in = 1'b0; step(1);
        end
        chk(vcount == v0, "R8 resync holds timer", vcount - v0, 0);
        ir_in = 1'b1;
        do_clear();

        // R4 same pattern oversampled still samples
        tmode = 1'b0;
        do_arm();
        v0 = vcount;
        for (int k = 0; k < 30; k++) begin
            ir_in = 1'b1; step(2); ir_in = 1'b0; step(1);
        end
        chk(vcount - v0 == 2, "R4 free-running sampling", vcount - v0, 2);
        ir_in = 1'b1;
        do_clear();
        step(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule